// File: doc/BRIEF.md
# Keyed Register Write Unlock

This block keeps a set of protected write targets closed until software writes a 32-bit magic value, 0xF123F456, to a key register. Once the matching value is written, the block stays open across any number of writes to the protected targets. Those targets are an internal configuration register whose bit 0 enables the serial-wire debug port, a window of flash addresses, and a privileged command register. The open state ends in two ways: when the command-start input pulses, or when software writes any other value to the key register.

All writes arrive on a single-cycle register write port with address, data and strobe. Each write is accepted or refused in the cycle it is presented. The block drives a write-enable output to the flash and command logic. It loads the configuration register itself. A protected write that arrives while the block is closed has no effect and raises a sticky error flag. Software clears that flag by writing 1 to it. A combinational read port returns the configuration, the status and a key register that always reads zero.

Address map (ADDR_W bits wide): an address with its top bit set is in the flash window. The register addresses are 0 (key), 1 (configuration), 2 (status) and 3 (command). Every other address is unmapped and is ignored.

Top module: `key_write_guard`

## Requirements
- R1: After reset the block is locked (`unlocked`=0), the error flag is 0, and the configuration register holds CFG_RST, whose default of 1 leaves debug enabled.
- R2: A write of 0xF123F456 to address 0 sets `unlocked` from the next cycle on. It stays set across any number of further writes until R3 or R4 clears it.
- R3: A write of any other value to address 0 clears `unlocked` from the next cycle on.
- R4: A cycle with `cmdStart` high clears `unlocked` from the next cycle on.
- R5: If a key write of 0xF123F456 and `cmdStart` fall in the same cycle, the block is locked in the next cycle, because clearing wins.
- R6: A write to address 1 loads `wrData[CFG_W-1:0]` into the configuration register on the next cycle, but only while unlocked. While locked the configuration register is unchanged.
- R7: `flashWrEn` is high in the same cycle as a write to an address with bit ADDR_W-1 set, and `cmdWrEn` is high in the same cycle as a write to address 3. Each is high only while unlocked.
- R8: A write to a protected target (flash window, address 1 or address 3) while locked sets the sticky `accErr` from the next cycle on. A write to address 2 with data bit 1 set clears `accErr`.
- R9: A read of address 0 always returns 0. Address 1 returns the zero-extended configuration register. Address 2 returns bit 0 = `unlocked` and bit 1 = `accErr`.
- R10: `dbgEn` equals configuration bit 0, so writing 0 to that bit while unlocked disables debug access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 32 | Write data |
| cmdStart | input | 1 | Pulse marking the start of a command |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 32 | Read data (combinational) |
| cfgOut | output | CFG_W | Protected configuration register |
| dbgEn | output | 1 | Debug port enable (configuration bit 0) |
| flashWrEn | output | 1 | Write enable to the flash window |
| cmdWrEn | output | 1 | Write enable to the command register |
| unlocked | output | 1 | Unlock state |
| accErr | output | 1 | Sticky refused-write flag |

## Verification
Two events can collide in one cycle: a key write and a command start. The first tries to open the block and the second closes it. The bench forces this with directed key-plus-start cycles, both from the locked and the unlocked state. It also leaves random stimulus free to produce the same overlap at a low rate. A bench model that applies the clear first judges every collision, and `unlocked` and the status read must show the locked state one cycle later.

// File: rtl/kwg_pkg.sv
package kwg_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hF123F456;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CMD  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic cfgLoad;
    logic errSet;
    logic errClr;
  } kwgStrb_t;
endpackage

// File: rtl/kwg_ctrl.sv
module kwg_ctrl
  import kwg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              cmdStart,
  output logic              unlockQ,
  output logic              flashWe,
  output logic              cmdWe,
  output kwgStrb_t          strb
);
  localparam int MID_W = ADDR_W - 2;

  logic isFlash, isReg;
  logic hitKey, hitCfg, hitStat, hitCmd;
  logic protHit, unlockNext;

  always_comb begin
    isFlash = wrAddr[ADDR_W-1];
    isReg   = (wrAddr[ADDR_W-1:2] == MID_W'(0));
    hitKey  = wrEn && isReg && (wrAddr[1:0] == SEL_KEY);
    hitCfg  = wrEn && isReg && (wrAddr[1:0] == SEL_CFG);
    hitStat = wrEn && isReg && (wrAddr[1:0] == SEL_STAT);
    hitCmd  = wrEn && isReg && (wrAddr[1:0] == SEL_CMD);
    protHit = (wrEn && isFlash) || hitCfg || hitCmd;
  end

  // Clear sources take priority over a matching key write.
  always_comb begin
    unlockNext = unlockQ;
    if (cmdStart)    unlockNext = 1'b0;
    else if (hitKey) unlockNext = (wrData == UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unlockQ <= 1'b0;
    else       unlockQ <= unlockNext;
  end

  always_comb begin
    flashWe      = wrEn && isFlash && unlockQ;
    cmdWe        = hitCmd && unlockQ;
    strb.cfgLoad = hitCfg && unlockQ;
    strb.errSet  = protHit && !unlockQ;
    strb.errClr  = hitStat && wrData[1];
  end
endmodule

// File: rtl/kwg_datapath.sv
module kwg_datapath
  import kwg_pkg::*;
#(
  parameter int             ADDR_W  = 8,
  parameter int             CFG_W   = 8,
  parameter logic [CFG_W-1:0] CFG_RST = CFG_W'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  kwgStrb_t          strb,
  input  logic [31:0]       wrData,
  input  logic              unlockQ,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CFG_W-1:0]  cfgQ,
  output logic              errQ,
  output logic [31:0]       rdData
);
  localparam int MID_W = ADDR_W - 2;
  localparam int PAD_W = 32 - CFG_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= CFG_RST;
      errQ <= 1'b0;
    end else begin
      if (strb.cfgLoad) cfgQ <= wrData[CFG_W-1:0];
      if (strb.errSet)      errQ <= 1'b1;
      else if (strb.errClr) errQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = 32'd0;
    if (rdAddr[ADDR_W-1:2] == MID_W'(0)) begin
      case (rdAddr[1:0])
        SEL_CFG:  rdData = {{PAD_W{1'b0}}, cfgQ};
        SEL_STAT: rdData = {30'd0, errQ, unlockQ};
        default:  rdData = 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/key_write_guard.sv
module key_write_guard
  import kwg_pkg::*;
#(
  parameter int             ADDR_W  = 8,
  parameter int             CFG_W   = 8,
  parameter logic [CFG_W-1:0] CFG_RST = CFG_W'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic [CFG_W-1:0]  cfgOut,
  output logic              dbgEn,
  output logic              flashWrEn,
  output logic              cmdWrEn,
  output logic              unlocked,
  output logic              accErr
);
  kwgStrb_t strb;

  kwg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmdStart(cmdStart), .unlockQ(unlocked), .flashWe(flashWrEn),
    .cmdWe(cmdWrEn), .strb(strb)
  );

  kwg_datapath #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .unlockQ(unlocked),
    .rdAddr(rdAddr), .cfgQ(cfgOut), .errQ(accErr), .rdData(rdData)
  );

  assign dbgEn = cfgOut[0];
endmodule

// File: rtl/kwg_checker.sv
module kwg_checker #(
  parameter int ADDR_W = 8,
  parameter int CFG_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic              cmdStart,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [31:0]       rdData,
  input logic [CFG_W-1:0]  cfgOut,
  input logic              flashWrEn,
  input logic              cmdWrEn,
  input logic              unlocked,
  input logic              accErr
);
  logic inRegs, keyWr, protWr;
  assign inRegs = (wrAddr[ADDR_W-1:2] == '0);
  assign keyWr  = wrEn && inRegs && (wrAddr[1:0] == 2'd0);
  assign protWr = wrEn && (wrAddr[ADDR_W-1] ||
                  (inRegs && (wrAddr[1:0] == 2'd1 || wrAddr[1:0] == 2'd3)));

  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && wrData == 32'hF123F456 && !cmdStart) |=> unlocked);
  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && wrData != 32'hF123F456) |=> !unlocked);
  p_start_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !unlocked);
  p_start_beats_key_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && keyWr) |=> !unlocked);
  p_cfg_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(cfgOut));
  p_no_enable_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> (!flashWrEn && !cmdWrEn));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (protWr && !unlocked) |=> accErr);
  p_key_reads_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == '0) |-> (rdData == 32'd0));
endmodule

bind key_write_guard kwg_checker #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/test_key_write_guard.sv
`timescale 1ns/1ps
module test_key_write_guard;
  localparam int ADDR_W = 8;
  localparam int CFG_W  = 8;
  localparam logic [31:0] KEYV = 32'hF123F456;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic cmdStart = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [CFG_W-1:0] cfgOut;
  logic dbgEn, flashWrEn, cmdWrEn, unlocked, accErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  // model state
  bit mUnl;
  bit mErr;
  logic [CFG_W-1:0] mCfg;

  always #2 clk = ~clk;

  key_write_guard #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) i_key_write_guard (.*);

  function automatic bit isFlash(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction
  function automatic bit regHit(logic [ADDR_W-1:0] a, int sel);
    return (a[ADDR_W-1:2] == '0) && (a[1:0] == sel[1:0]);
  endfunction
  function automatic logic [31:0] expRead(logic [ADDR_W-1:0] a);
    if (regHit(a, 1)) return {24'd0, mCfg};
    if (regHit(a, 2)) return {30'd0, mErr, mUnl};
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Checks registered state; call away from the clock edge.
  task automatic chkState();
    chk("R2/R3/R4 unlocked", {31'd0, unlocked}, {31'd0, mUnl});
    chk("R6 cfgOut", {24'd0, cfgOut}, {24'd0, mCfg});
    chk("R8 accErr", {31'd0, accErr}, {31'd0, mErr});
    chk("R10 dbgEn", {31'd0, dbgEn}, {31'd0, mCfg[0]});
  endtask

  // Drive one cycle at negedge, check combinational outputs, advance model at posedge.
  task automatic cyc(bit we, logic [ADDR_W-1:0] a, logic [31:0] d, bit st,
                     logic [ADDR_W-1:0] ra);
    bit prot, nUnl;
    @(negedge clk);
    chkState();
    wrEn = we; wrAddr = a; wrData = d; cmdStart = st; rdAddr = ra;
    #1;
    chk("R7 flashWrEn", {31'd0, flashWrEn}, {31'd0, we && isFlash(a) && mUnl});
    chk("R7 cmdWrEn", {31'd0, cmdWrEn}, {31'd0, we && regHit(a, 3) && mUnl});
    chk("R9 rdData", rdData, expRead(ra));
    prot = we && (isFlash(a) || regHit(a, 1) || regHit(a, 3));
    nUnl = mUnl;
    if (st) nUnl = 1'b0;
    else if (we && regHit(a, 0)) nUnl = (d == KEYV);
    if (we && regHit(a, 1) && mUnl) mCfg = d[CFG_W-1:0];
    if (prot && !mUnl) mErr = 1'b1;
    else if (we && regHit(a, 2) && d[1]) mErr = 1'b0;
    mUnl = nUnl;
    @(posedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mUnl = 1'b0; mErr = 1'b0; mCfg = 8'd1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 unlocked", {31'd0, unlocked}, 32'd0);
    chk("R1 accErr", {31'd0, accErr}, 32'd0);
    chk("R1 cfgOut", {24'd0, cfgOut}, 32'd1);
    rstN = 1'b1;

    // R9: key reads zero after a correct key write
    cyc(1, 8'd0, KEYV, 0, 8'd0);
    cyc(0, 8'd0, 0, 0, 8'd0);
    chk("R9 key read zero", rdData, 32'd0);
    // R2: several protected writes keep it open; R10 debug off
    cyc(1, 8'h85, 32'h1, 0, 8'd2);
    cyc(1, 8'd1, 32'h0, 0, 8'd1);
    cyc(1, 8'd3, 32'h7, 0, 8'd1);
    cyc(1, 8'hFF, 32'h9, 0, 8'd2);
    // R4: command start closes
    cyc(0, 8'd0, 0, 1, 8'd2);
    cyc(1, 8'd1, 32'h1, 0, 8'd1);   // refused, R8 error set
    cyc(1, 8'd2, 32'h2, 0, 8'd2);   // R8 clear
    // R5: key and start same cycle, from locked
    cyc(1, 8'd0, KEYV, 1, 8'd2);
    cyc(0, 8'd0, 0, 0, 8'd2);
    // R5 from unlocked
    cyc(1, 8'd0, KEYV, 0, 8'd2);
    cyc(1, 8'd0, KEYV, 1, 8'd2);
    cyc(0, 8'd0, 0, 0, 8'd2);
    // R3: wrong key closes
    cyc(1, 8'd0, KEYV, 0, 8'd2);
    cyc(1, 8'd0, KEYV ^ 32'h1, 0, 8'd2);
    cyc(1, 8'h80, 32'h5, 0, 8'd2);  // refused flash write
    // unmapped address ignored
    cyc(1, 8'd9, 32'hFFFF, 0, 8'd9);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a, ra;
      logic [31:0] d;
      int r = $urandom_range(0, 9);
      a = (r < 3) ? 8'd0 : (r < 5) ? 8'd1 : (r == 5) ? 8'd2 : (r == 6) ? 8'd3
          : (r == 7) ? ADDR_W'($urandom) : (8'h80 | ADDR_W'($urandom));
      d = ($urandom_range(0, 1) == 1) ? KEYV : $urandom;
      ra = ADDR_W'($urandom_range(0, 4));
      cyc($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 9) == 0, ra);
    end
    @(negedge clk);
    chkState();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule